// File: doc/BRIEF.md
# Configurable Serial Transmit Frame Engine

This block turns characters from a small transmit queue into asynchronous serial frames on a single output line. The character length (6, 7 or 8 bits), the parity rule (even, odd, forced 0, forced 1 or none) and the stop length (one or two bits) are held in a format word. Commands turn the transmitter on and off, flush the queue and abort the frame in progress, and hold the line in a break condition until a separate command releases it.

Bit timing comes from outside. An external divider pulses `bit_tick` for one clock cycle once per bit period. Every bit the engine sends starts on a tick edge and lasts until the next one. Characters are written through a byte strobe. The format word and the commands share one configuration write port, and a select input picks between them. The engine reports whether the queue is empty and whether it is full. While idle, disabled or flushed, the line rests high.

Top module: `serial_tx_engine`

## Requirements
- R1: After reset `txd` is 1, `fifo_empty` is 1, `fifo_full` is 0, the transmitter is off, and the format is 8 data bits, no parity, one stop bit.
- R2: A frame is a 0 start bit, then the data bits least significant first, then the optional parity bit, then 1-valued stop bits. Each bit lasts exactly one tick period. `txd` changes only on a clock edge where `bit_tick` is 1, except in a cycle that follows a command write.
- R3: Format bits [2:1] choose the length: 11 gives 6 data bits, 10 gives 7, and 00 or 01 give 8. Data bits above the length are not sent.
- R4: Format bits [5:3] choose parity: 000 sets the bit so that the data plus parity has an even number of ones, 001 makes that count odd, 010 always sends 0, 011 always sends 1, and 1xx sends no parity bit.
- R5: Format bit 7 set gives two stop bits and clear gives one. The next start bit therefore follows the previous start bit by 1+L+P+S tick periods.
- R6: The queue holds 16 characters and sends them in write order. `fifo_full` rises at 16 entries. A write while full is dropped. `fifo_full` and `fifo_empty` are never both 1.
- R7: Command bit 4 turns the transmitter on and bit 5 turns it off. When both are 1, off wins. A frame already started completes, and no new frame starts while the transmitter is off.
- R8: Command bit 1 empties the queue and returns the line to idle high within one cycle, aborting any frame in progress.
- R9: Command bit 7 drives `txd` low from the next cycle until command bit 8 is written. When both are 1, bit 8 wins.
- R10: The format is sampled when a frame starts. A format write during a frame leaves that frame unchanged and applies to the next one.

Configuration writes use `cfg_sel`: 0 writes the format word and 1 writes a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit period from the external divider |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 writes the format word, 1 writes a command |
| cfg_wdata | input | 9 | Format word or command bits |
| chr_we | input | 1 | Character write strobe |
| chr_wdata | input | 8 | Character to queue |
| txd | output | 1 | Serial output line, idle high |
| fifo_empty | output | 1 | Queue holds no character |
| fifo_full | output | 1 | Queue holds 16 characters |

## Verification
The serial line is sampled mid-bit by a bench receiver and compared with frames computed from the format fields. Data patterns with different weights are sent under each length and parity setting, so a wrong bit order, a missing mask of the upper bits or a swapped parity sense each shows up as a different bit. Back-to-back frames are timed start to start, which separates one stop bit from two. Mid-frame disable and mid-frame format writes show that a started frame keeps its shape. A 17-write burst, a flush and a break each show a distinct effect on the line or the flags.

// File: rtl/stx_pkg.sv
`timescale 1ns/1ps
// Shared constants, command/format bit positions and the decoded format type.
package stx_pkg;
    localparam int CHAR_W  = 8;
    localparam int FRAME_W = 12;   // start + 8 data + parity + 2 stop
    localparam int BITS_W  = 4;
    localparam int CFG_W   = 9;

    // command bit positions
    localparam int CMD_TX_RESET = 1;
    localparam int CMD_TX_ON    = 4;
    localparam int CMD_TX_OFF   = 5;
    localparam int CMD_BRK_SET  = 7;
    localparam int CMD_BRK_CLR  = 8;

    // format bit positions
    localparam int MD_LEN_LSB = 1;
    localparam int MD_PAR_LSB = 3;
    localparam int MD_STOP2   = 7;

    typedef enum logic [1:0] {
        PAR_EVEN = 2'b00,
        PAR_ODD  = 2'b01,
        PAR_ZERO = 2'b10,
        PAR_ONE  = 2'b11
    } par_kind_e;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_off;
        par_kind_e  par_kind;
        logic       stop2;
    } fmt_t;

    localparam fmt_t FMT_RESET = '{len_code: 2'b00, par_off: 1'b1,
                                   par_kind: PAR_EVEN, stop2: 1'b0};

    // Unpack a raw format word into its fields.
    function automatic fmt_t decode_fmt(input logic [CFG_W-1:0] w);
        fmt_t f;
        f.len_code = w[MD_LEN_LSB +: 2];
        f.par_off  = w[MD_PAR_LSB + 2];
        f.par_kind = par_kind_e'(w[MD_PAR_LSB +: 2]);
        f.stop2    = w[MD_STOP2];
        return f;
    endfunction
endpackage

// File: rtl/stx_fifo.sv
`timescale 1ns/1ps
// Character queue: DEPTH entries, in order; pushes when full and pops when
// empty are ignored. Assumes a flush beats a push in the same cycle.
module stx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_ptr, wr_ptr;
    logic [AW:0]      count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];

    // Storage write; no reset needed for the data array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/stx_framer.sv
`timescale 1ns/1ps
// Builds the complete bit vector of one frame (bit 0 sent first) and its
// length from a character and a format. Bits above the frame length are 1.
module stx_framer
    import stx_pkg::*;
(
    input  logic [CHAR_W-1:0]  char_i,
    input  fmt_t               fmt_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [BITS_W-1:0]  nbits_o
);
    int                nd;
    logic              par_b;
    logic [CHAR_W-1:0] masked;

    // Frame assembly: start, masked data, parity, stop fill.
    always_comb begin
        case (fmt_i.len_code)
            2'b11:   nd = 6;
            2'b10:   nd = 7;
            default: nd = 8;
        endcase
        masked = '0;
        for (int i = 0; i < CHAR_W; i++) begin
            if (i < nd) masked[i] = char_i[i];
        end
        case (fmt_i.par_kind)
            PAR_EVEN: par_b = ^masked;
            PAR_ODD:  par_b = ~^masked;
            PAR_ZERO: par_b = 1'b0;
            default:  par_b = 1'b1;
        endcase
        frame_o    = '1;
        frame_o[0] = 1'b0;
        for (int i = 0; i < CHAR_W; i++) begin
            if (i < nd) frame_o[1+i] = masked[i];
        end
        if (!fmt_i.par_off) frame_o[1+nd] = par_b;
        nbits_o = BITS_W'(1 + nd + (fmt_i.par_off ? 0 : 1) + (fmt_i.stop2 ? 2 : 1));
    end
endmodule

// File: rtl/stx_shifter.sv
`timescale 1ns/1ps
// Bit sequencer: on each tick either moves to the next bit of the current
// frame or, when none is in flight and starting is allowed, loads a new
// frame and pops the queue. Assumes frame_i/nbits_i describe the queue head.
module stx_shifter
    import stx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort,
    input  logic               tick,
    input  logic               start_ok,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [BITS_W-1:0]  nbits_i,
    output logic               pop,
    output logic               busy,
    output logic               line
);
    logic [FRAME_W-1:0] sh;
    logic [BITS_W-1:0]  left;
    logic               more;

    assign more = busy && (left != '0);
    assign pop  = tick && !more && start_ok && !abort;

    // Advance, load or idle on each bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            sh   <= '1;
            left <= '0;
            busy <= 1'b0;
            line <= 1'b1;
        end else if (tick) begin
            if (more) begin
                sh   <= {1'b1, sh[FRAME_W-1:1]};
                line <= sh[1];
                left <= left - 1'b1;
            end else if (start_ok) begin
                sh   <= frame_i;
                line <= frame_i[0];
                left <= nbits_i - 1'b1;
                busy <= 1'b1;
            end else begin
                busy <= 1'b0;
                line <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/serial_tx_engine.sv
`timescale 1ns/1ps
// Top: holds the enable, break and format state, decodes configuration
// writes and ties queue, framer and sequencer together. Assumes bit_tick is
// a single-cycle pulse from an external divider.
module serial_tx_engine
    import stx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              chr_we,
    input  logic [CHAR_W-1:0] chr_wdata,
    output logic              txd,
    output logic              fifo_empty,
    output logic              fifo_full
);
    logic               cmd_we, fmt_we, flush;
    logic               tx_en_q, brk_q;
    fmt_t               fmt_q;
    logic [CHAR_W-1:0]  head;
    logic [FRAME_W-1:0] frame;
    logic [BITS_W-1:0]  nbits;
    logic               pop, shift_busy, line;

    assign cmd_we = cfg_we && cfg_sel;
    assign fmt_we = cfg_we && !cfg_sel;
    assign flush  = cmd_we && cfg_wdata[CMD_TX_RESET];

    // Enable, break and format registers; off and break-clear take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;
            brk_q   <= 1'b0;
            fmt_q   <= FMT_RESET;
        end else begin
            if (cmd_we) begin
                if (cfg_wdata[CMD_TX_OFF])      tx_en_q <= 1'b0;
                else if (cfg_wdata[CMD_TX_ON])  tx_en_q <= 1'b1;
                if (cfg_wdata[CMD_BRK_CLR])     brk_q   <= 1'b0;
                else if (cfg_wdata[CMD_BRK_SET]) brk_q  <= 1'b1;
            end
            if (fmt_we) fmt_q <= decode_fmt(cfg_wdata);
        end
    end

    stx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(CHAR_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (chr_we),
        .din   (chr_wdata),
        .pop   (pop),
        .dout  (head),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    stx_framer u_framer (
        .char_i  (head),
        .fmt_i   (fmt_q),
        .frame_o (frame),
        .nbits_o (nbits)
    );

    stx_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (flush),
        .tick     (bit_tick),
        .start_ok (tx_en_q && !fifo_empty),
        .frame_i  (frame),
        .nbits_i  (nbits),
        .pop      (pop),
        .busy     (shift_busy),
        .line     (line)
    );

    assign txd = brk_q ? 1'b0 : line;
endmodule

// File: rtl/stx_checker.sv
`timescale 1ns/1ps
// Temporal checks on the engine's ports and its enable/busy state.
module stx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_tick,
    input logic       cfg_we,
    input logic       cfg_sel,
    input logic [8:0] cfg_wdata,
    input logic       txd,
    input logic       fifo_empty,
    input logic       fifo_full,
    input logic       tx_en_q,
    input logic       shift_busy
);
    // R2: the line moves only on tick edges or after a command write
    a_r2_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && !(cfg_we && cfg_sel)) |=> $stable(txd));

    // R6: flags exclusive
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    // R7: off command wins
    a_r7_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel && cfg_wdata[5]) |=> !tx_en_q);

    // R7: no frame starts while off
    a_r7_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en_q && !shift_busy) |=> !shift_busy);

    // R8: flush empties the queue
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel && cfg_wdata[1]) |=> fifo_empty);

    // R9: break start pulls the line low
    a_r9_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel && cfg_wdata[7] && !cfg_wdata[8]) |=> !txd);
endmodule

bind serial_tx_engine stx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .txd        (txd),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .tx_en_q    (tx_en_q),
    .shift_busy (shift_busy)
);

// File: tb/serial_tx_engine_bench.sv
`timescale 1ns/1ps
// Directed bench: a mid-bit receiver checks frames against expectations
// computed from the format fields.
module serial_tx_engine_bench;
    localparam int TICKP = 8;
    localparam realtime BITNS = TICKP * 8.0;

    logic       clk = 0, rst_n = 0, bit_tick = 0;
    logic       cfg_we = 0, cfg_sel = 0;
    logic [8:0] cfg_wdata = '0;
    logic       chr_we = 0;
    logic [7:0] chr_wdata = '0;
    logic       txd, fifo_empty, fifo_full;
    int         checks = 0, errors = 0;
    bit         done = 0;

    serial_tx_engine u_serial_tx_engine (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .chr_we(chr_we), .chr_wdata(chr_wdata),
        .txd(txd), .fifo_empty(fifo_empty), .fifo_full(fifo_full)
    );

    always #4 clk = ~clk;

    // Bit-rate divider model: one-cycle pulse every TICKP cycles.
    initial begin
        int tcnt = 0;
        forever begin
            @(negedge clk);
            tcnt = (tcnt + 1) % TICKP;
            bit_tick = (tcnt == 0);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input bit sel, input logic [8:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic put_char(input logic [7:0] d);
        @(negedge clk);
        chr_we = 1; chr_wdata = d;
        @(negedge clk);
        chr_we = 0;
    endtask

    function automatic logic [8:0] fmt_word(input logic [1:0] lc, input logic [2:0] pc, input bit two);
        return {1'b0, two, 1'b0, pc, lc, 1'b0};
    endfunction

    function automatic void exp_frame(input logic [7:0] d, input logic [1:0] lc,
                                      input logic [2:0] pc, input bit two,
                                      output logic [15:0] v, output int n);
        int  nd = (lc == 2'b11) ? 6 : (lc == 2'b10) ? 7 : 8;
        int  k;
        logic par = 0;
        v = '1; v[0] = 0;
        for (int i = 0; i < nd; i++) begin v[1+i] = d[i]; par ^= d[i]; end
        k = 1 + nd;
        if (!pc[2]) begin
            case (pc[1:0])
                2'b00: v[k] = par;
                2'b01: v[k] = ~par;
                2'b10: v[k] = 1'b0;
                default: v[k] = 1'b1;
            endcase
            k++;
        end
        n = k + (two ? 2 : 1);
    endfunction

    // Wait for a start bit, then sample n bits at their middles.
    task automatic rx(input int n, output logic [15:0] v, output realtime t0, output bit got);
        int w = 0;
        got = 0; v = '1; t0 = 0;
        while (txd !== 1'b0 && w < 3000) begin @(negedge clk); w++; end
        if (txd !== 1'b0) return;
        t0 = $realtime; got = 1;
        repeat (TICKP/2) @(negedge clk);
        v[0] = txd;
        for (int i = 1; i < n; i++) begin
            repeat (TICKP) @(negedge clk);
            v[i] = txd;
        end
    endtask

    task automatic expect_frame(input string req, input logic [7:0] d, input logic [1:0] lc,
                                input logic [2:0] pc, input bit two, output realtime t0);
        logic [15:0] e, v, m;
        int n; bit got;
        exp_frame(d, lc, pc, two, e, n);
        rx(n, v, t0, got);
        m = 16'((32'd1 << n) - 1);
        check(got && ((v & m) == (e & m)), req, "frame bits", v & m, e & m);
    endtask

    task automatic quiet(input int cyc, output int lows);
        lows = 0;
        for (int i = 0; i < cyc; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
    endtask

    task automatic t_reset;
        check(txd === 1'b1, "R1", "txd", txd, 1);
        check(fifo_empty === 1'b1, "R1", "empty", fifo_empty, 1);
        check(fifo_full === 1'b0, "R1", "full", fifo_full, 0);
        put_char(8'h5A);
        begin int l; quiet(3*10*TICKP, l); check(l == 0, "R1", "line while off", l, 0); end
        cfg_write(1, 9'h002);
    endtask

    task automatic t_basic;
        realtime a, b;
        cfg_write(1, 9'h010);
        put_char(8'hA5); put_char(8'h01);
        expect_frame("R1 R2", 8'hA5, 2'b00, 3'b100, 0, a);
        expect_frame("R2", 8'h01, 2'b00, 3'b100, 0, b);
        check((b - a) == 10*BITNS, "R5", "one-stop spacing", longint'(b - a), longint'(10*BITNS));
    endtask

    task automatic t_formats;
        realtime t;
        cfg_write(0, fmt_word(2'b10, 3'b000, 0));
        put_char(8'hFB);
        expect_frame("R3 R4 even 7b", 8'hFB, 2'b10, 3'b000, 0, t);
        cfg_write(0, fmt_word(2'b00, 3'b001, 0));
        put_char(8'h37);
        expect_frame("R4 odd 8b", 8'h37, 2'b00, 3'b001, 0, t);
        cfg_write(0, fmt_word(2'b11, 3'b010, 0));
        put_char(8'hFF);
        expect_frame("R3 R4 space 6b", 8'hFF, 2'b11, 3'b010, 0, t);
        cfg_write(0, fmt_word(2'b11, 3'b011, 0));
        put_char(8'hC0);
        expect_frame("R3 R4 mark 6b", 8'hC0, 2'b11, 3'b011, 0, t);
    endtask

    task automatic t_two_stop;
        realtime a, b;
        cfg_write(0, fmt_word(2'b00, 3'b100, 1));
        put_char(8'h81); put_char(8'h7E);
        expect_frame("R5", 8'h81, 2'b00, 3'b100, 1, a);
        expect_frame("R5", 8'h7E, 2'b00, 3'b100, 1, b);
        check((b - a) == 11*BITNS, "R5", "two-stop spacing", longint'(b - a), longint'(11*BITNS));
        cfg_write(0, fmt_word(2'b00, 3'b100, 0));
    endtask

    task automatic t_fifo_full;
        realtime t; int l;
        cfg_write(1, 9'h020);
        for (int i = 0; i < 15; i++) put_char(8'(i*7 + 1));
        check(fifo_full === 1'b0, "R6", "full at 15", fifo_full, 0);
        put_char(8'(15*7 + 1));
        check(fifo_full === 1'b1, "R6", "full at 16", fifo_full, 1);
        put_char(8'hEE);
        cfg_write(1, 9'h010);
        for (int i = 0; i < 16; i++) expect_frame("R6 order", 8'(i*7 + 1), 2'b00, 3'b100, 0, t);
        quiet(3*10*TICKP, l);
        check(l == 0, "R6", "dropped write not sent", l, 0);
        check(fifo_empty === 1'b1, "R6", "empty after drain", fifo_empty, 1);
    endtask

    task automatic t_disable;
        realtime t; int l;
        cfg_write(1, 9'h030);
        put_char(8'h99);
        quiet(3*10*TICKP, l);
        check(l == 0, "R7", "both bits: stays off", l, 0);
        cfg_write(1, 9'h002);
        cfg_write(1, 9'h010);
        put_char(8'h3C); put_char(8'h55);
        fork
            expect_frame("R7 in-flight completes", 8'h3C, 2'b00, 3'b100, 0, t);
            begin wait (txd === 1'b0); cfg_write(1, 9'h020); end
        join
        quiet(3*10*TICKP, l);
        check(l == 0, "R7", "no start while off", l, 0);
        check(fifo_empty === 1'b0, "R7", "char kept", fifo_empty, 0);
        cfg_write(1, 9'h010);
        expect_frame("R7 resume", 8'h55, 2'b00, 3'b100, 0, t);
    endtask

    task automatic t_flush;
        int l;
        put_char(8'h11); put_char(8'h22); put_char(8'h33);
        wait (txd === 1'b0);
        repeat (TICKP*2) @(negedge clk);
        cfg_write(1, 9'h002);
        check(fifo_empty === 1'b1, "R8", "empty after flush", fifo_empty, 1);
        check(txd === 1'b1, "R8", "line idle after abort", txd, 1);
        quiet(3*10*TICKP, l);
        check(l == 0, "R8", "nothing sent after flush", l, 0);
    endtask

    task automatic t_break;
        int l;
        cfg_write(1, 9'h080);
        check(txd === 1'b0, "R9", "break low", txd, 0);
        quiet(5*TICKP, l);
        check(l == 5*TICKP, "R9", "break held", l, 5*TICKP);
        cfg_write(1, 9'h180);
        check(txd === 1'b1, "R9", "clear wins / released", txd, 1);
    endtask

    task automatic t_mode_change;
        realtime t;
        put_char(8'hC3); put_char(8'h2D);
        fork
            expect_frame("R10 old format kept", 8'hC3, 2'b00, 3'b100, 0, t);
            begin wait (txd === 1'b0); cfg_write(0, fmt_word(2'b11, 3'b011, 1)); end
        join
        expect_frame("R10 new format next", 8'h2D, 2'b11, 3'b011, 1, t);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R2: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_basic;
        t_formats;
        t_two_stop;
        t_fifo_full;
        t_disable;
        t_flush;
        t_break;
        cfg_write(1, 9'h010);
        t_mode_change;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule